// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives a 16x-oversampling enable for a UART from a fixed 48 MHz reference clock. The divide ratio is an integer of up to 14 bits plus a fraction in eighths. The integer sets the base period in reference cycles. The fraction is realised by a 3-bit phase accumulator: on a set share of ticks it stretches the following period by one reference cycle. A fraction code n therefore gives an average divide of N + n/8. At a divisor of 1, which gives 3 Mbaud at 16x, the block ticks on every reference cycle. At the top of the integer range the rate falls to roughly 183 baud.

Software-side logic presents a new integer and fraction and pulses a load strobe. The block holds the request in a pending register and applies it only when the current period ends. A period already in progress is never cut short. The output `tick` drives the sample and shift enables of the receiver and transmitter.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, `tick` is 0. After reset the active divisor is integer 1 with fraction 0, so from the first cycle after release `tick` is high on every reference cycle until a loaded divisor takes effect.
- R2: With integer N (1..16383) and fraction 0, ticks repeat exactly every N reference cycles.
- R3: With integer N and fraction code n (0..7, meaning n/8), each period is N or N+1 cycles, and any 8 consecutive periods total exactly 8*N + n cycles.
- R4: An integer field of 0 is treated as 1. The divide is then 1 plus the fraction, and the block runs at its highest rate.
- R5: A `div_load` pulse captures `div_int` and `div_frac` into a pending register. The pending divisor becomes active on the first tick after capture. The period running at the time of the load completes at its old length.
- R6: The fraction accumulator restarts at zero whenever a new divisor becomes active. The first period under a new divisor is therefore exactly N cycles.
- R7: When the period is 2 cycles or more, `tick` is high for exactly one reference cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_int | input | 14 | Integer part of the divisor (0 acts as 1) |
| div_frac | input | 3 | Fraction code n, adds n/8 to the divisor |
| div_load | input | 1 | One-cycle strobe that captures a new divisor |
| tick | output | 1 | 16x baud enable, one reference cycle wide |

## Verification
The hardest case to reach from the ports is a divisor change that lands in the middle of a long period. In that case the old period must run to completion and the new ratio must start on the next boundary. The stimulus first runs a divisor of 10 and locks to one of its ticks. It pulses the load four cycles later, then measures the interval that contains the load and the one after it. The fractional cases are checked by locking to the tick at which each new divisor is applied. From there eight consecutive periods are summed, which also pins down the accumulator restart.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int INT_W  = 14;
  localparam int FRAC_W = 3;

  typedef struct packed {
    logic [INT_W-1:0]  whole;
    logic [FRAC_W-1:0] part;
  } divisor_t;
endpackage

// File: rtl/baud_div_hold.sv
module baud_div_hold
  import baud_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_i,
  input  divisor_t new_i,
  input  logic     tick_i,
  output divisor_t sel_o,
  output logic     apply_o
);
  divisor_t pend_q, pend_d;
  divisor_t act_q, act_d;
  logic     pend_vld_q, pend_vld_d;

  assign apply_o = tick_i & pend_vld_q;
  assign sel_o   = pend_vld_q ? pend_q : act_q;

  always_comb begin
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    act_d      = act_q;
    if (apply_o) begin
      act_d      = pend_q;
      pend_vld_d = 1'b0;
    end
    if (load_i) begin
      pend_d     = new_i;
      pend_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      act_q      <= '{whole: INT_W'(1), part: '0};
    end else begin
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
      act_q      <= act_d;
    end
  end

  // R5: the active divisor only changes on a tick boundary
  a_r5_no_midperiod_change: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(act_q));
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              clear_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac_i};

  always_comb begin
    acc_d   = acc_q;
    carry_o = 1'b0;
    if (tick_i) begin
      if (clear_i) begin
        acc_d = frac_i;
      end else begin
        acc_d   = sum[FRAC_W-1:0];
        carry_o = sum[FRAC_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R3: the phase advances only on ticks
  a_r3_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(acc_q));
  // R6: no stretch on the first period after a divisor change
  a_r6_restart_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && clear_i) |-> !carry_o);
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [INT_W-1:0] reload_i,
  output logic             zero_o
);
  logic [INT_W-1:0] cnt_q, cnt_d;

  assign zero_o = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i)                cnt_d = reload_i;
    else if (run_i && !zero_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: between ticks the counter steps down by one
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              div_load,
  output logic              tick
);
  logic             run_q;
  logic             at_zero;
  logic             apply;
  logic             carry;
  divisor_t         sel;
  logic [INT_W-1:0] eff_int;
  logic [INT_W-1:0] reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assign tick = run_q & at_zero;

  baud_div_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (div_load),
    .new_i   ('{whole: div_int, part: div_frac}),
    .tick_i  (tick),
    .sel_o   (sel),
    .apply_o (apply)
  );

  baud_frac_acc u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .clear_i (apply),
    .frac_i  (sel.part),
    .carry_o (carry)
  );

  always_comb begin
    eff_int = (sel.whole == '0) ? INT_W'(1) : sel.whole;
    reload  = eff_int - 1'b1 + {{(INT_W-1){1'b0}}, carry};
  end

  baud_period_cnt u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_q),
    .tick_i   (tick),
    .reload_i (reload),
    .zero_o   (at_zero)
  );

  // R7: a period of two or more cycles gives a single-cycle tick
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload != '0) |=> !tick);
  // R4: a zero integer with no carry gives back-to-back ticks
  a_r4_zero_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel.whole == '0 && !carry) |=> tick);
  // R1: no tick while in reset
  always_comb begin
    if (!rst_n) a_r1_quiet_reset: assert (!tick);
  end
endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
  logic        clk;
  logic        rst_n;
  logic [13:0] div_int;
  logic [2:0]  div_frac;
  logic        div_load;
  logic        tick;

  int checks;
  int fails;
  int cyc;
  bit done;

  localparam int NV = 6;
  localparam int V_INT [NV] = '{5, 0, 0, 1, 2, 3000};
  localparam int V_FRAC[NV] = '{3, 0, 5, 7, 4, 1};
  localparam int V_SUM [NV] = '{43, 8, 13, 15, 20, 24001};

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac),
    .div_load(div_load), .tick(tick)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_tick(output int c);
    @(negedge clk);
    while (!tick) @(negedge clk);
    c = cyc;
  endtask

  // load at a negedge; returns the cycle of the tick that applies it
  task automatic load_div(input int n, input int f, output int c_apply);
    @(negedge clk);
    div_int  = 14'(n);
    div_frac = 3'(f);
    div_load = 1'b1;
    @(negedge clk);
    div_load = 1'b0;
    if (tick) c_apply = cyc;
    else      next_tick(c_apply);
  endtask

  initial begin
    cyc = 0;
    done = 1'b0;
    while (!done) begin
      @(posedge clk);
      if (cyc > 190000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int c0, c1, c2, eff, sum, first, per;
    bit in_range;
    checks = 0;
    fails  = 0;
    rst_n = 1'b0;
    div_int = '0;
    div_frac = '0;
    div_load = 1'b0;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
    rst_n = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(tick == 1'b1, "R1 divide-by-1 after reset", int'(tick), 1);
    end

    // table of divisors: R2, R3, R4, R6, R7
    for (int v = 0; v < NV; v++) begin
      eff = (V_INT[v] == 0) ? 1 : V_INT[v];
      load_div(V_INT[v], V_FRAC[v], c0);
      sum = 0;
      in_range = 1'b1;
      first = 0;
      for (int k = 0; k < 8; k++) begin
        next_tick(c1);
        per = c1 - c0;
        if (k == 0) first = per;
        if (per != eff && per != eff + 1) in_range = 1'b0;
        sum += per;
        c0 = c1;
      end
      check(sum == V_SUM[v], "R3/R4 eight-period total", sum, V_SUM[v]);
      check(first == eff, "R6 first period after apply", first, eff);
      check(in_range, "R2/R7 period within N..N+1", int'(in_range), 1);
    end

    // R5: load mid-period, the running period keeps its old length
    load_div(10, 0, c0);
    next_tick(c0);
    repeat (4) @(negedge clk);
    div_int = 14'd3;
    div_frac = 3'd0;
    div_load = 1'b1;
    @(negedge clk);
    div_load = 1'b0;
    next_tick(c1);
    check(c1 - c0 == 10, "R5 old period completes", c1 - c0, 10);
    next_tick(c2);
    check(c2 - c1 == 3, "R5 new divisor after boundary", c2 - c1, 3);
    @(negedge clk);
    check(tick == 1'b0, "R7 tick one cycle wide", int'(tick), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule